// File: doc/BRIEF.md
# Reset Sequencer with Cause Capture

This block holds a small microcontroller core in reset and records why the most recent reset or wake-up happened. It takes a power-on pulse, an external master-clear pin with a configuration enable, a watchdog time-out pulse, two wake-from-sleep inputs (pin change and comparator change), and the core's sleep flag. From these it drives the internal reset, the five upper cause flags of the status register (status bits 7..3), and a load strobe that sets the program counter to all ones.

The reset latch is released only after a start-up delay counter has seen the effective master-clear level high for `DLY_CYC` consecutive cycles. Any later master-clear, watchdog or wake event sets the latch again, clears the counter and writes a pattern specific to that event into the cause flags. Some patterns keep selected flag bits unchanged. Status bits 2..0 are not touched by this block.

The flag output `cause_o[4:0]` maps to status bits 7..3 as follows: [4] pin-change wake flag, [3] comparator wake flag, [2] spare (always written 0), [1] time-out flag, [0] power-down flag.

Top module: `rcs_reset_seq`

## Requirements
- R1: While `por_i` is high at a clock edge, the next cycle shows `core_rst_o`=1, `cause_o`=5'b00011 and `pc_load_o`=1, and the start-up count is cleared.
- R2: The start-up counter advances only in cycles where the effective master-clear level is high, and is held at zero while that level is low. `core_rst_o` falls after `DLY_CYC` consecutive high cycles with no new event in between.
- R3: With `mclr_en_i`=0 the effective master-clear level is constant high, and `mclr_pin_i` has no effect on any output.
- R4: `mclr_pin_i` passes through a two-flop synchronizer. A pin fall, with the enable set, reaches the outputs after the third rising clock edge.
- R5: A master-clear fall outside sleep writes 0 to `cause_o[4:2]` and leaves `cause_o[1:0]` unchanged.
- R6: A master-clear fall during sleep writes `cause_o`=5'b00010.
- R7: A watchdog time-out during sleep writes `cause_o`=5'b00000. Outside sleep it writes 0 to `cause_o[4:1]` and leaves `cause_o[0]` unchanged.
- R8: A pin-change wake during sleep writes 5'b10010, and a comparator wake during sleep writes 5'b01010. Both wake inputs are ignored while `sleep_i`=0.
- R9: Every event in R1 and R5 to R8 gives a one-cycle `pc_load_o` pulse (with `pc_val_o` all ones), sets `core_rst_o`, and restarts the start-up count.
- R10: Events in the same cycle resolve in this order: power-on, master-clear, watchdog, pin-change wake, comparator wake. Only the winning event's pattern is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on pulse, synchronous active-high reset |
| mclr_pin_i | input | 1 | External master-clear pin, asynchronous, active low |
| mclr_en_i | input | 1 | Configuration bit: 1 = pin acts as master-clear |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| wake_pin_i | input | 1 | Pin-change wake request |
| wake_cmp_i | input | 1 | Comparator-change wake request |
| sleep_i | input | 1 | Core is in sleep |
| core_rst_o | output | 1 | Internal reset to the core |
| cause_o | output | 5 | Status bits 7..3 cause flags |
| pc_load_o | output | 1 | Program counter reset load strobe |
| pc_val_o | output | PC_W | Program counter reset value (all ones) |

## Verification
The bench targets the partly preserving patterns. A design that wrote a full pattern for master-clear or watchdog outside sleep would wipe the time-out or power-down flag the bench has already set. It also drives a master-clear rise partway through a count followed by a short low pulse; a counter that was not cleared while the level was low would release the core early. Coincident events are driven in the same cycle, so a wrong priority writes a visibly different pattern. Wake requests outside sleep and pin activity with the enable off are also driven; a design that honoured either would pulse `pc_load_o` or change the flags.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [2:0] {EV_NONE, EV_MCLR, EV_WDT, EV_WPIN, EV_WCMP} ev_e;
  localparam int FLG_W = 5;
  // cause flags: [4] pin wake, [3] cmp wake, [2] spare, [1] time-out, [0] power-down
  localparam logic [FLG_W-1:0] FLG_POR      = 5'b00011;
  localparam logic [FLG_W-1:0] FLG_MCLR_SLP = 5'b00010;
  localparam logic [FLG_W-1:0] FLG_WDT_SLP  = 5'b00000;
  localparam logic [FLG_W-1:0] FLG_WPIN     = 5'b10010;
  localparam logic [FLG_W-1:0] FLG_WCMP     = 5'b01010;
endpackage

// File: rtl/rcs_mclr_front.sv
module rcs_mclr_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic en_i,
  output logic eff_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   eff_d_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign eff_o = en_i ? sync_q[SYNC_STAGES-1] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) eff_d_q <= 1'b0;
    else     eff_d_q <= eff_o;
  end

  assign fall_o = eff_d_q & ~eff_o;
endmodule

// File: rtl/rcs_arb.sv
module rcs_arb
  import rcs_pkg::*;
(
  input  logic mclr_fall_i,
  input  logic wdt_i,
  input  logic wpin_i,
  input  logic wcmp_i,
  input  logic sleep_i,
  output ev_e  ev_o
);
  always_comb begin
    if (mclr_fall_i)          ev_o = EV_MCLR;
    else if (wdt_i)           ev_o = EV_WDT;
    else if (sleep_i && wpin_i) ev_o = EV_WPIN;
    else if (sleep_i && wcmp_i) ev_o = EV_WCMP;
    else                      ev_o = EV_NONE;
  end
endmodule

// File: rtl/rcs_flags.sv
module rcs_flags
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ev_e              ev_i,
  input  logic             sleep_i,
  output logic [FLG_W-1:0] flags_o,
  output logic             pc_load_o
);
  logic [FLG_W-1:0] flags_q;
  logic             pc_load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= FLG_POR;
      pc_load_q <= 1'b1;
    end else begin
      pc_load_q <= (ev_i != EV_NONE);
      case (ev_i)
        EV_MCLR: flags_q <= sleep_i ? FLG_MCLR_SLP : {3'b000, flags_q[1:0]};
        EV_WDT:  flags_q <= sleep_i ? FLG_WDT_SLP  : {4'b0000, flags_q[0]};
        EV_WPIN: flags_q <= FLG_WPIN;
        EV_WCMP: flags_q <= FLG_WCMP;
        default: flags_q <= flags_q;
      endcase
    end
  end

  assign flags_o   = flags_q;
  assign pc_load_o = pc_load_q;

  assert_por_flags_R1: assert property (@(posedge clk)
    rst |=> (flags_q == FLG_POR && pc_load_q));
  assert_wake_only_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(flags_q[4]) || $rose(flags_q[3])) |-> $past(sleep_i));
endmodule

// File: rtl/rcs_delay.sv
module rcs_delay #(
  parameter int DLY_CYC = 4_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_any_i,
  input  logic mclr_eff_i,
  output logic latch_o
);
  localparam int CNT_W = (DLY_CYC > 2) ? $clog2(DLY_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DLY_CYC - 1);

  logic             latch_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || ev_any_i) begin
      latch_q <= 1'b1;
      cnt_q   <= '0;
    end else if (latch_q) begin
      if (!mclr_eff_i) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q   <= '0;
        latch_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign latch_o = latch_q;

  assert_cnt_held_low_R2: assert property (@(posedge clk) disable iff (rst)
    !mclr_eff_i |=> (cnt_q == '0));
  assert_release_after_count_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_q) |-> ($past(cnt_q) == LAST && $past(mclr_eff_i)));
endmodule

// File: rtl/rcs_reset_seq.sv
module rcs_reset_seq
  import rcs_pkg::*;
#(
  parameter int DLY_CYC     = 4_500_000,
  parameter int PC_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            por_i,
  input  logic            mclr_pin_i,
  input  logic            mclr_en_i,
  input  logic            wdt_to_i,
  input  logic            wake_pin_i,
  input  logic            wake_cmp_i,
  input  logic            sleep_i,
  output logic            core_rst_o,
  output logic [4:0]      cause_o,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_val_o
);
  logic mclr_eff, mclr_fall;
  ev_e  ev;

  rcs_mclr_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(por_i), .pin_i(mclr_pin_i), .en_i(mclr_en_i),
    .eff_o(mclr_eff), .fall_o(mclr_fall)
  );

  rcs_arb u_arb (
    .mclr_fall_i(mclr_fall), .wdt_i(wdt_to_i), .wpin_i(wake_pin_i),
    .wcmp_i(wake_cmp_i), .sleep_i(sleep_i), .ev_o(ev)
  );

  rcs_flags u_flags (
    .clk(clk), .rst(por_i), .ev_i(ev), .sleep_i(sleep_i),
    .flags_o(cause_o), .pc_load_o(pc_load_o)
  );

  rcs_delay #(.DLY_CYC(DLY_CYC)) u_delay (
    .clk(clk), .rst(por_i), .ev_any_i(ev != EV_NONE),
    .mclr_eff_i(mclr_eff), .latch_o(core_rst_o)
  );

  assign pc_val_o = '1;

  assert_pc_load_in_reset_R9: assert property (@(posedge clk) disable iff (por_i)
    pc_load_o |-> core_rst_o);
endmodule

// File: tb/rcs_reset_seq_bench.sv
module rcs_reset_seq_bench;
  localparam int D = 16;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por = 1'b1, pin = 1'b1, en = 1'b1, wdt = 1'b0, wpin = 1'b0, wcmp = 1'b0, slp = 1'b0;
  logic core_rst, pc_load;
  logic [4:0] cause;
  logic [7:0] pc_val;

  rcs_reset_seq #(.DLY_CYC(D), .PC_W(8), .SYNC_STAGES(2)) u_rcs_reset_seq (
    .clk(clk), .por_i(por), .mclr_pin_i(pin), .mclr_en_i(en), .wdt_to_i(wdt),
    .wake_pin_i(wpin), .wake_cmp_i(wcmp), .sleep_i(slp), .core_rst_o(core_rst),
    .cause_o(cause), .pc_load_o(pc_load), .pc_val_o(pc_val)
  );

  int checks = 0, errors = 0, cyc = 0;
  string ph = "R1";
  bit started = 0, done = 0;

  // behavioural reference
  bit m_rst, m_pcl, m_p1, m_p2, m_prev;
  bit [4:0] m_flg;
  int m_cnt;

  always @(posedge clk) begin
    bit eff, fall;
    int ev;
    cyc++;
    if (por) begin
      m_rst = 1; m_cnt = 0; m_flg = 5'b00011; m_pcl = 1;
      m_p1 = 0; m_p2 = 0; m_prev = 0; started = 1;
    end else begin
      eff  = en ? m_p2 : 1'b1;
      fall = m_prev && !eff;
      m_prev = eff; m_p2 = m_p1; m_p1 = pin;
      ev = fall ? 1 : wdt ? 2 : (slp && wpin) ? 3 : (slp && wcmp) ? 4 : 0;
      case (ev)
        1: m_flg = slp ? 5'b00010 : {3'b000, m_flg[1:0]};
        2: m_flg = slp ? 5'b00000 : {4'b0000, m_flg[0]};
        3: m_flg = 5'b10010;
        4: m_flg = 5'b01010;
        default: ;
      endcase
      m_pcl = (ev != 0);
      if (ev != 0) begin m_rst = 1; m_cnt = 0; end
      else if (m_rst) begin
        if (!eff) m_cnt = 0;
        else begin
          m_cnt++;
          if (m_cnt == D) begin m_rst = 0; m_cnt = 0; end
        end
      end
    end
  end

  always @(negedge clk) if (started && !done) begin
    checks++;
    if (core_rst !== m_rst || cause !== m_flg || pc_load !== m_pcl || pc_val !== 8'hFF) begin
      errors++;
      $display("FAIL %s cyc=%0d actual rst=%b cause=%b pcl=%b pc=%h expected rst=%b cause=%b pcl=%b pc=ff",
               ph, cyc, core_rst, cause, pc_load, pc_val, m_rst, m_flg, m_pcl);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    tick(3);
    por = 0; ph = "R1/R4"; tick(4);
    ph = "R2"; tick(25);
    pin = 0; tick(10); pin = 1; tick(8);
    pin = 0; tick(5); pin = 1; tick(25);
    ph = "R3"; en = 0;
    for (int i = 0; i < 6; i++) begin pin = ~pin; tick(4); end
    pin = 1; tick(10); en = 1; tick(5);
    ph = "R7"; wdt = 1; tick(); wdt = 0; tick(25);
    slp = 1; wdt = 1; tick(); wdt = 0; tick(25);
    ph = "R8"; slp = 0; wpin = 1; tick(); wpin = 0; wcmp = 1; tick(); wcmp = 0; tick(5);
    slp = 1; wpin = 1; tick(); wpin = 0; tick(25);
    wcmp = 1; tick(); wcmp = 0; tick(25);
    ph = "R6"; pin = 0; tick(5); pin = 1; tick(25);
    ph = "R5"; wpin = 1; tick(); wpin = 0; tick(25);
    slp = 0; pin = 0; tick(5); pin = 1; tick(25);
    ph = "R10"; slp = 1; wdt = 1; wpin = 1; wcmp = 1; tick(); wdt = 0; tick();
    wpin = 0; wcmp = 0; tick(25);
    wpin = 1; wcmp = 1; tick(); wpin = 0; wcmp = 0; tick(25);
    en = 0; pin = 0; tick(4); en = 1; wdt = 1; tick(); wdt = 0; tick(4); pin = 1; tick(25);
    ph = "R9/R1"; por = 1; wdt = 1; tick(); wdt = 0; tick(); por = 0; tick(25);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule